// File: doc/BRIEF.md
# Registered Address/Command Buffer with Delayed Parity Check

This block is the logic core of a clocked address/command register on a memory module. On each rising clock edge it captures an input word and drives registered copies of it to the memory devices. A width-mode input picks between two mappings. In the first, 25 inputs each drive one output. In the second, 14 inputs each drive two outputs, which gives a fan-out of two. In fan-out mode, an arrangement input places the second copy of each bit either as a separate upper group or interleaved with the first copy.

Two active-low select inputs gate the update. The outputs keep their values only while both selects are high. The first select is also registered and presented as an output bit. When the second select is tied low, gating never happens, and the first select acts as one more registered data bit.

A parity bit arrives one cycle after the word it covers. It is combined with that word, and the result is sent out so that a second device can be chained after this one. A mismatch pulls an active-low error flag low for a fixed stretch of cycles. An asynchronous active-low reset overrides everything else.

Top module: `addr_cmd_register`

## Requirements
- R1: In 1:1 mode (`width_sel`=0), when an update is enabled, `q_out[i]` equals the `d_in[i]` sampled at the last rising edge, for i = 0..24.
- R2: In 1:1 mode, `q_out[27:25]` are driven low after an updating edge.
- R3: In 1:2 mode (`width_sel`=1) with arrangement A (`arr_sel`=0), `q_out[i]` and `q_out[i+14]` both equal the sampled `d_in[i]` for i = 0..13. In this mode `d_in[24:14]` has no effect on `q_out`.
- R4: In 1:2 mode with arrangement B (`arr_sel`=1), `q_out[2i]` and `q_out[2i+1]` both equal the sampled `d_in[i]` for i = 0..13.
- R5: When `cs0_n` and `cs1_n` are both high at an edge, `q_out` and `q_cs_n` keep their previous values.
- R6: When either select is low at an edge, `q_out` updates and `q_cs_n` takes the sampled `cs0_n`. With `cs1_n` held low, `q_cs_n` follows `cs0_n` one cycle later on every edge.
- R7: While `rst_n` is low, `q_out`, `q_cs_n` and `par_out` are low and `err_n` is high. This takes effect without waiting for a clock edge and overrides select gating.
- R8: `par_out` is the XOR of two things: the active data bits of the word captured one edge earlier (all 25 bits in 1:1 mode, `d_in[13:0]` in 1:2 mode, using the mode at capture) and the `par_in` sampled one edge later. It is registered on that later edge. The cycle after reset, the earlier word counts as all zeros.
- R9: An edge at which that XOR is 1 drives `err_n` low for exactly 2 cycles. A further mismatch during the stretch restarts the 2-cycle count. Otherwise `err_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| width_sel | input | 1 | 0: 25-bit 1:1, 1: 14-bit 1:2 |
| arr_sel | input | 1 | 1:2 arrangement, 0: A (upper group), 1: B (interleaved) |
| cs0_n | input | 1 | First select, active low, also registered to `q_cs_n` |
| cs1_n | input | 1 | Second select, active low |
| d_in | input | 25 | Data word |
| par_in | input | 1 | Parity of the word from the previous cycle |
| q_out | output | 28 | Registered data outputs |
| q_cs_n | output | 1 | Registered first select |
| par_out | output | 1 | Parity residual for a chained device |
| err_n | output | 1 | Stretched parity error flag, active low |

## Verification
The assertions assume that the mode inputs and data are stable around the rising edge. They also assume the checks start only after at least one clocked reset cycle, so the parity stage holds a defined value. The bench changes every input two nanoseconds after the rising edge and holds reset low across several edges before releasing it. The random stimulus keeps `par_in` equal to the true parity most of the time. It inserts occasional deliberate mismatches, including back-to-back ones, so that both the quiet path and the restart of the error stretch are exercised.

// File: rtl/acr_pkg.sv
package acr_pkg;
   typedef enum logic {WIDTH_ONE = 1'b0, WIDTH_TWO = 1'b1} width_e;
   typedef enum logic {ARR_UPPER = 1'b0, ARR_WEAVE = 1'b1} arr_e;

   // width of a down-counter that must hold values 0..n
   function automatic int cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/acr_fanout_map.sv
module acr_fanout_map #(
   parameter int IN_BITS   = 25,
   parameter int PAIR_BITS = 14,
   localparam int OUT_BITS = 2 * PAIR_BITS
) (
   input  logic [IN_BITS-1:0]  d,
   input  logic                width_sel,
   input  logic                arr_sel,
   output logic [OUT_BITS-1:0] mapped
);
   import acr_pkg::*;

   for (genvar o = 0; o < OUT_BITS; o++) begin : g_bit
      localparam int SRC_UP = o % PAIR_BITS;
      localparam int SRC_WV = o / 2;
      logic one_bit;
      if (o < IN_BITS) begin : g_used
         assign one_bit = d[o];
      end else begin : g_spare
         assign one_bit = 1'b0;
      end
      always_comb begin
         if (width_e'(width_sel) == WIDTH_ONE)
            mapped[o] = one_bit;
         else if (arr_e'(arr_sel) == ARR_UPPER)
            mapped[o] = d[SRC_UP];
         else
            mapped[o] = d[SRC_WV];
      end
   end
endmodule

// File: rtl/acr_data_reg.sv
module acr_data_reg #(
   parameter int OUT_BITS = 28
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs0_n,
   input  logic                cs1_n,
   input  logic [OUT_BITS-1:0] mapped,
   output logic [OUT_BITS-1:0] q,
   output logic                q_cs_n
);
   logic upd;
   assign upd = !(cs0_n && cs1_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= '0;
         q_cs_n <= 1'b0;
      end else if (upd) begin
         q      <= mapped;
         q_cs_n <= cs0_n;
      end
   end

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs0_n && cs1_n) |=> ($stable(q) && $stable(q_cs_n)));

   assert_sel_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cs1_n |=> (q_cs_n == $past(cs0_n)));
endmodule

// File: rtl/acr_parity_check.sv
module acr_parity_check #(
   parameter int IN_BITS   = 25,
   parameter int PAIR_BITS = 14,
   parameter int ERR_HOLD  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IN_BITS-1:0] d,
   input  logic               width_sel,
   input  logic               par_in,
   output logic               par_out,
   output logic               err_n
);
   import acr_pkg::*;
   localparam int CW = cnt_width(ERR_HOLD);

   logic          word_par;
   logic          residual;
   logic [CW-1:0] hold_cnt;

   assign residual = word_par ^ par_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_par <= 1'b0;
         par_out  <= 1'b0;
         hold_cnt <= '0;
      end else begin
         word_par <= (width_e'(width_sel) == WIDTH_TWO) ? ^d[PAIR_BITS-1:0] : ^d;
         par_out  <= residual;
         if (residual)
            hold_cnt <= CW'(ERR_HOLD);
         else if (hold_cnt != '0)
            hold_cnt <= hold_cnt - CW'(1);
      end
   end

   assign err_n = (hold_cnt == '0);

   assert_err_on_mismatch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      residual |=> !err_n);

   assert_par_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
      residual |=> par_out);

   assert_err_needs_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_n) |-> $past(par_out ^ 1'b0) || par_out);
endmodule

// File: rtl/addr_cmd_register.sv
module addr_cmd_register #(
   parameter int IN_BITS   = 25,
   parameter int PAIR_BITS = 14,
   parameter int ERR_HOLD  = 2,
   localparam int OUT_BITS = 2 * PAIR_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                width_sel,
   input  logic                arr_sel,
   input  logic                cs0_n,
   input  logic                cs1_n,
   input  logic [IN_BITS-1:0]  d_in,
   input  logic                par_in,
   output logic [OUT_BITS-1:0] q_out,
   output logic                q_cs_n,
   output logic                par_out,
   output logic                err_n
);
   if (PAIR_BITS > IN_BITS) begin : g_bad_pair
      $error("PAIR_BITS must not exceed IN_BITS");
   end
   if (IN_BITS > OUT_BITS) begin : g_bad_out
      $error("IN_BITS must fit in the fan-out width");
   end
   if (ERR_HOLD < 1) begin : g_bad_hold
      $error("ERR_HOLD must be at least 1");
   end

   logic [OUT_BITS-1:0] mapped;

   acr_fanout_map #(.IN_BITS(IN_BITS), .PAIR_BITS(PAIR_BITS)) i_map (
      .d(d_in), .width_sel(width_sel), .arr_sel(arr_sel), .mapped(mapped));

   acr_data_reg #(.OUT_BITS(OUT_BITS)) i_dreg (
      .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1_n(cs1_n),
      .mapped(mapped), .q(q_out), .q_cs_n(q_cs_n));

   acr_parity_check #(.IN_BITS(IN_BITS), .PAIR_BITS(PAIR_BITS), .ERR_HOLD(ERR_HOLD)) i_par (
      .clk(clk), .rst_n(rst_n), .d(d_in), .width_sel(width_sel),
      .par_in(par_in), .par_out(par_out), .err_n(err_n));

   assert_straight_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cs0_n && cs1_n) && !width_sel) |=> (q_out[IN_BITS-1:0] == $past(d_in)));

   assert_upper_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cs0_n && cs1_n) && width_sel && !arr_sel) |=>
         (q_out[PAIR_BITS-1:0] == q_out[OUT_BITS-1:PAIR_BITS]));

   assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (q_out == '0 && !q_cs_n && !par_out && err_n));
endmodule

// File: tb/test_addr_cmd_register.sv
module test_addr_cmd_register;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        width_sel = 1'b0, arr_sel = 1'b0, cs0_n = 1'b1, cs1_n = 1'b1;
   logic [24:0] d_in = '0;
   logic        par_in = 1'b0;
   logic [27:0] q_out;
   logic        q_cs_n, par_out, err_n;

   int checks = 0, fails = 0;

   // expected state
   logic [27:0] e_q = '0;
   logic        e_cs = 1'b0, e_wpar = 1'b0, e_pout = 1'b0;
   int          e_cnt = 0;

   always #4 clk = ~clk;

   addr_cmd_register i_addr_cmd_register (
      .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .arr_sel(arr_sel),
      .cs0_n(cs0_n), .cs1_n(cs1_n), .d_in(d_in), .par_in(par_in),
      .q_out(q_out), .q_cs_n(q_cs_n), .par_out(par_out), .err_n(err_n));

   function automatic logic [27:0] map_f(logic [24:0] d, logic w, logic a);
      logic [27:0] r;
      for (int o = 0; o < 28; o++) begin
         if (!w)     r[o] = (o < 25) ? d[o] : 1'b0;
         else if (!a) r[o] = d[o % 14];
         else         r[o] = d[o / 2];
      end
      return r;
   endfunction

   function automatic logic word_par_f(logic [24:0] d, logic w);
      return w ? ^d[13:0] : ^d;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(string qreq);
      chk(qreq, {4'h0, q_out}, {4'h0, e_q});
      chk("R6 q_cs_n", {31'h0, q_cs_n}, {31'h0, e_cs});
      chk("R8 par_out", {31'h0, par_out}, {31'h0, e_pout});
      chk("R9 err_n", {31'h0, err_n}, {31'h0, (e_cnt == 0)});
   endtask

   // one clock with the current inputs, then model update and compare
   task automatic step(string qreq);
      logic res;
      @(posedge clk);
      #2;
      if (!rst_n) begin
         e_q = '0; e_cs = 1'b0; e_wpar = 1'b0; e_pout = 1'b0; e_cnt = 0;
      end else begin
         if (!(cs0_n && cs1_n)) begin
            e_q  = map_f(d_in, width_sel, arr_sel);
            e_cs = cs0_n;
         end
         res    = e_wpar ^ par_in;
         e_pout = res;
         if (res) e_cnt = 2;
         else if (e_cnt > 0) e_cnt--;
         e_wpar = word_par_f(d_in, width_sel);
      end
      check_all(qreq);
   endtask

   function automatic string q_tag(logic w, logic a, logic hold);
      if (hold) return "R5 hold";
      if (!w)   return "R1/R2 straight";
      return a ? "R4 weave" : "R3 upper";
   endfunction

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h1234_5678));
      // R7 reset state
      #2; check_all("R7 reset");
      repeat (3) step("R7 reset");
      rst_n = 1'b1;

      // R1 R2 straight
      cs0_n = 1'b0; cs1_n = 1'b1; d_in = 25'h1ff_ffff; par_in = 1'b0;
      step("R1 straight");
      chk("R2 spare low", {29'h0, q_out[27:25]}, 32'h0);
      par_in = e_wpar; d_in = 25'h0a5_5a5a; step("R1 straight");

      // R5 hold with both high
      cs0_n = 1'b1; cs1_n = 1'b1; par_in = e_wpar; d_in = 25'h000_0000;
      step("R5 hold");
      par_in = e_wpar; d_in = 25'h155_5555; step("R5 hold");

      // R6 second select low, first one toggles
      cs1_n = 1'b0;
      for (int k = 0; k < 4; k++) begin
         cs0_n = k[0]; par_in = e_wpar; d_in = 25'(k * 32'h0031_337);
         step("R6 follow");
      end

      // R3 upper arrangement, high input bits ignored
      width_sel = 1'b1; arr_sel = 1'b0;
      par_in = e_wpar; d_in = 25'h1ff_c000; step("R3 upper ignore");
      chk("R3 high bits ignored", {4'h0, q_out}, 32'h0);
      par_in = e_wpar; d_in = 25'h000_2a5b; step("R3 upper");

      // R4 weave
      arr_sel = 1'b1; par_in = e_wpar; d_in = 25'h000_3001; step("R4 weave");
      chk("R4 pair 0", {30'h0, q_out[1:0]}, 32'h3);
      chk("R4 pair 13", {30'h0, q_out[27:26]}, 32'h3);

      // R9 single mismatch: low for two cycles
      par_in = ~e_wpar; d_in = 25'h0; step("R9 single");
      par_in = e_wpar; step("R9 single");
      par_in = e_wpar; step("R9 single");
      chk("R9 released", {31'h0, err_n}, 32'h1);

      // R9 retrigger
      par_in = ~e_wpar; step("R9 retrig");
      par_in = e_wpar; step("R9 retrig");
      par_in = ~e_wpar; step("R9 retrig");
      par_in = e_wpar; step("R9 retrig");
      chk("R9 still low after retrigger", {31'h0, err_n}, 32'h0);

      // R7 async reset during hold and error stretch
      par_in = ~e_wpar; cs0_n = 1'b1; cs1_n = 1'b1; step("R5 hold");
      #1 rst_n = 1'b0;
      #1;
      e_q = '0; e_cs = 1'b0; e_wpar = 1'b0; e_pout = 1'b0; e_cnt = 0;
      check_all("R7 async reset");
      step("R7 reset priority");
      rst_n = 1'b1;

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic hold;
         width_sel = $urandom_range(0, 1);
         arr_sel   = $urandom_range(0, 1);
         hold      = ($urandom_range(0, 3) == 0);
         cs0_n     = hold ? 1'b1 : 1'($urandom_range(0, 1));
         cs1_n     = hold ? 1'b1 : (cs0_n ? 1'b0 : 1'($urandom_range(0, 1)));
         d_in      = 25'($urandom);
         par_in    = e_wpar ^ ($urandom_range(0, 7) == 0);
         step(q_tag(width_sel, arr_sel, hold));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule